// File: doc/BRIEF.md
# Programmable Prioritized Interrupt Controller

This block gathers a set of interrupt request lines and turns them into two requests for a processor. One is a critical request, intended for a machine-check style exception. The other is a normal external-interrupt request. Each source line has its own settings, all held in registers behind a simple bus:

- active polarity;
- level or edge triggering;
- capture straight from the clock domain, or through a two-flop synchronizer for lines that arrive asynchronously;
- an enable mask;
- the output that it drives.

Edge-triggered status bits stay latched until software writes a one to them. Level-triggered bits follow the conditioned input.

For the normal output, the block also forms a vector. The vector is a programmable base plus four times the index of the winning pending source. The winner is the normal-routed source with the smallest 5-bit priority value, and ties go to the lower index. Software uses this vector to dispatch straight to a handler. Bus reads return data one cycle after the request. Writes take effect at the clock edge that carries them.

Top module: `irqc_top`

## Requirements
- R1: After reset, both request outputs and the vector are 0, the enable, trigger, async, route, base and priority registers read 0, and polarity reads all ones. Register word addresses: raw status 0x00, masked status 0x01, enable 0x02, polarity 0x03 (1 = active high), trigger 0x04 (1 = edge), async 0x05 (1 = synchronizer), route 0x06 (1 = critical), base 0x07, vector 0x08, and the priority of source i at 0x20+i (bits 4:0). Source i is bit i of each register.
- R2: A synchronous level source that is enabled and routed normal raises norm_irq on the third rising edge after its input becomes active, and not on the second.
- R3: With polarity bit 0, a low input counts as active and a high input as inactive.
- R4: An edge source latches its raw status bit on an inactive-to-active transition. The bit stays set after the input returns inactive. Writing 0 to that bit leaves it set, and writing 1 clears it.
- R5: A level source's raw status bit cannot be cleared by writing 1 while its input remains active.
- R6: An async source adds one clock of latency: its request appears on the fourth rising edge after activation, not the third.
- R7: The masked status register reads raw status AND enable. A pending source whose enable bit is 0 drives neither output.
- R8: An enabled pending source with route bit 1 drives crit_irq and not norm_irq; with route bit 0 it drives norm_irq and not crit_irq.
- R9: The vector equals base + 4*index of the winning source, and equals base when no normal-routed enabled source is pending.
- R10: Among pending normal sources, the smallest priority value wins, and on equal values the lower index wins.
- R11: Critical-routed sources never take part in vector selection, whatever their priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Interrupt source lines |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid one cycle after a read strobe |
| crit_irq | output | 1 | Critical (machine-check) request |
| norm_irq | output | 1 | Normal external-interrupt request |
| vector | output | DW | Handler vector for the normal request |

## Verification
The bench targets exact latency. It samples the request one cycle before and at the expected edge for synchronous and async capture. A design with a missing or extra synchronizer stage fails there.

Edge bits are pulsed for a single cycle and then probed with a zero write and a one write. A design that treats edge bits as level bits, or ignores write-one-to-clear, shows the wrong status. A level source is also write-cleared while it is still asserted, which catches a clear that wrongly wins over the live level.

Priority ties, reversals and a low-value critical source are mixed with normal sources. A picker with inverted ordering, a tie-break toward the higher index, or one that lets critical sources into the vector then reports the wrong vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 6;

  typedef enum logic [ADDR_W-1:0] {
    REG_RAW    = 6'h00,
    REG_MASKED = 6'h01,
    REG_ENABLE = 6'h02,
    REG_POL    = 6'h03,
    REG_TRIG   = 6'h04,
    REG_ASYNC  = 6'h05,
    REG_ROUTE  = 6'h06,
    REG_BASE   = 6'h07,
    REG_VECTOR = 6'h08
  } reg_addr_e;

  // priority fields occupy a window starting here, one word per source
  localparam logic [ADDR_W-1:0] PRIO_WIN = 6'h20;
endpackage

// File: rtl/irqc_src_cell.sv
module irqc_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic pol_hi,
  input  logic edge_mode,
  input  logic async_mode,
  input  logic clr,
  output logic act,
  output logic stat
);
  logic ff1, ff2, prev_q, sig, rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff1    <= 1'b0;
      ff2    <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      ff1    <= irq;
      ff2    <= ff1;
      prev_q <= act;
    end
  end

  assign sig  = async_mode ? ff2 : ff1;
  assign act  = pol_hi ? sig : ~sig;
  assign rise = act & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst)            stat <= 1'b0;
    else if (edge_mode) stat <= rise | (stat & ~clr);  // a new edge beats a clear
    else                stat <= act;
  end
endmodule

// File: rtl/irqc_prio_pick.sv
module irqc_prio_pick #(
  parameter int N  = 29,
  parameter int PW = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic            any,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best_p;

  always_comb begin
    any    = 1'b0;
    idx    = '0;
    best_p = '1;
    // ascending scan with strict compare: equal values keep the lower index
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!any || prio[i*PW +: PW] < best_p)) begin
        any    = 1'b1;
        idx    = IW'(i);
        best_p = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC = 29,
  parameter int DW    = 32,
  parameter int PW    = 5,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              crit_irq,
  output logic              norm_irq,
  output logic [DW-1:0]     vector
);
  logic [N_SRC-1:0] en_q, pol_q, trig_q, async_q, route_q;
  logic [DW-1:0]    base_q;
  logic [PW-1:0]    prio_q [N_SRC];
  logic [N_SRC*PW-1:0] prio_flat;
  logic [N_SRC-1:0] stat_raw, act_vec, clr_vec, masked, norm_req;
  logic             wr, rd, pick_any;
  logic [IW-1:0]    pick_idx;
  logic [DW-1:0]    vec_next;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;
  assign clr_vec = (wr && bus_addr == REG_RAW) ? bus_wdata[N_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      pol_q   <= '1;
      trig_q  <= '0;
      async_q <= '0;
      route_q <= '0;
      base_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        REG_ENABLE: en_q    <= bus_wdata[N_SRC-1:0];
        REG_POL:    pol_q   <= bus_wdata[N_SRC-1:0];
        REG_TRIG:   trig_q  <= bus_wdata[N_SRC-1:0];
        REG_ASYNC:  async_q <= bus_wdata[N_SRC-1:0];
        REG_ROUTE:  route_q <= bus_wdata[N_SRC-1:0];
        REG_BASE:   base_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst)
          prio_q[g] <= '0;
        else if (wr && bus_addr == (PRIO_WIN + ADDR_W'(g)))
          prio_q[g] <= bus_wdata[PW-1:0];
      end
      assign prio_flat[g*PW +: PW] = prio_q[g];

      irqc_src_cell u_cell (
        .clk        (clk),
        .rst        (rst),
        .irq        (irq_in[g]),
        .pol_hi     (pol_q[g]),
        .edge_mode  (trig_q[g]),
        .async_mode (async_q[g]),
        .clr        (clr_vec[g]),
        .act        (act_vec[g]),
        .stat       (stat_raw[g])
      );
    end
  endgenerate

  assign masked   = stat_raw & en_q;
  assign norm_req = masked & ~route_q;

  irqc_prio_pick #(.N(N_SRC), .PW(PW)) u_pick (
    .req  (norm_req),
    .prio (prio_flat),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  assign vec_next = pick_any ? base_q + (DW'(pick_idx) << 2) : base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crit_irq <= 1'b0;
      norm_irq <= 1'b0;
      vector   <= '0;
    end else begin
      crit_irq <= |(masked & route_q);
      norm_irq <= pick_any;
      vector   <= vec_next;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      bus_rdata <= '0;
      if (bus_addr >= PRIO_WIN && bus_addr < PRIO_WIN + ADDR_W'(N_SRC)) begin
        bus_rdata[PW-1:0] <= prio_q[bus_addr - PRIO_WIN];
      end else begin
        case (bus_addr)
          REG_RAW:    bus_rdata[N_SRC-1:0] <= stat_raw;
          REG_MASKED: bus_rdata[N_SRC-1:0] <= masked;
          REG_ENABLE: bus_rdata[N_SRC-1:0] <= en_q;
          REG_POL:    bus_rdata[N_SRC-1:0] <= pol_q;
          REG_TRIG:   bus_rdata[N_SRC-1:0] <= trig_q;
          REG_ASYNC:  bus_rdata[N_SRC-1:0] <= async_q;
          REG_ROUTE:  bus_rdata[N_SRC-1:0] <= route_q;
          REG_BASE:   bus_rdata <= base_q;
          REG_VECTOR: bus_rdata <= vector;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N  = 29,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  stat_raw,
  input logic [N-1:0]  act_vec,
  input logic [N-1:0]  trig_q,
  input logic [N-1:0]  clr_vec,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  route_q,
  input logic [DW-1:0] base_q,
  input logic          crit_irq,
  input logic          norm_irq,
  input logic [DW-1:0] vector
);
  // R7: nothing enabled means no request on either output next cycle
  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> (!crit_irq && !norm_irq));

  // R8: a critical request needs an enabled, pending, critical-routed source
  a_r8_crit_source: assert property (@(posedge clk) disable iff (rst)
    crit_irq |-> $past(|(stat_raw & en_q & route_q)));

  // R9: idle normal output presents the base as vector
  a_r9_idle_base: assert property (@(posedge clk) disable iff (rst)
    !norm_irq |-> (vector == $past(base_q)));

  // R4: a latched edge bit survives any cycle without a clear for it
  a_r4_edge_hold: assert property (@(posedge clk) disable iff (rst)
    ((($past(stat_raw & trig_q & ~clr_vec)) & trig_q & ~stat_raw) == '0));

  // R5: level bits track the conditioned input regardless of writes
  a_r5_level_track: assert property (@(posedge clk) disable iff (rst)
    (((stat_raw ^ $past(act_vec)) & ~$past(trig_q)) == '0));
endmodule

bind irqc_top irqc_checker #(.N(N_SRC), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .stat_raw (stat_raw),
  .act_vec  (act_vec),
  .trig_q   (trig_q),
  .clr_vec  (clr_vec),
  .en_q     (en_q),
  .route_q  (route_q),
  .base_q   (base_q),
  .crit_irq (crit_irq),
  .norm_irq (norm_irq),
  .vector   (vector)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int N = 29;
  localparam int DW = 32;
  localparam logic [31:0] BASE = 32'h0004_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata, vector;
  logic crit_irq, norm_irq;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_v = 1'b0;
  logic [N-1:0] en_sh = '0;

  always #5 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .crit_irq(crit_irq), .norm_irq(norm_irq), .vector(vector)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when the read result is valid
  always @(posedge clk) rd_v <= bus_en && !bus_we;
  always @(negedge clk) begin
    if (rd_v) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: actual=%h expected=<none>", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bread(input logic [5:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_en(input logic [N-1:0] e);
    en_sh = e;
    bwrite(6'h02, 32'(e));
  endtask

  task automatic pins(input logic c, input logic n, input logic [31:0] v, input string tag);
    check({31'd0, crit_irq}, {31'd0, c}, {tag, " crit"});
    check({31'd0, norm_irq}, {31'd0, n}, {tag, " norm"});
    check(vector, v, {tag, " vector"});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    pins(1'b0, 1'b0, 32'h0, "R1 reset");
    bread(6'h02, 32'h0, "R1 enable");
    bread(6'h03, 32'h1FFF_FFFF, "R1 polarity");
    bread(6'h04, 32'h0, "R1 trigger");
    bread(6'h06, 32'h0, "R1 route");
    bread(6'h07, 32'h0, "R1 base");
    bread(6'h25, 32'h0, "R1 prio5");

    bwrite(6'h07, BASE);
    bread(6'h07, BASE, "R9 base readback");

    // R2 sync level latency
    set_en(29'h8);
    irq_in[3] = 1'b1;
    cyc(2);
    pins(1'b0, 1'b0, BASE, "R2 before");
    cyc(1);
    pins(1'b0, 1'b1, BASE + 32'd12, "R2 after");
    bread(6'h00, 32'h8, "R2 raw");
    // R5 level bit not clearable while active
    bwrite(6'h00, 32'h8);
    bread(6'h00, 32'h8, "R5 raw after clear");
    irq_in[3] = 1'b0;
    cyc(3);
    pins(1'b0, 1'b0, BASE, "R9 none pending");

    // R3 polarity: source 5 active low
    bwrite(6'h03, ~(32'h20));
    set_en(29'h20);
    cyc(3);
    pins(1'b0, 1'b1, BASE + 32'd20, "R3 low active");
    irq_in[5] = 1'b1;
    cyc(3);
    pins(1'b0, 1'b0, BASE, "R3 high inactive");
    irq_in[5] = 1'b0;
    bwrite(6'h03, 32'hFFFF_FFFF);
    set_en('0);
    cyc(3);

    // R4 edge capture and write-one-to-clear
    bwrite(6'h04, 32'h80);
    set_en(29'h80);
    irq_in[7] = 1'b1;
    cyc(1);
    irq_in[7] = 1'b0;
    cyc(3);
    pins(1'b0, 1'b1, BASE + 32'd28, "R4 latched");
    bread(6'h00, 32'h80, "R4 raw latched");
    bwrite(6'h00, 32'h0);
    bread(6'h00, 32'h80, "R4 zero write");
    bwrite(6'h00, 32'h80);
    bread(6'h00, 32'h0, "R4 one write");
    cyc(1);
    pins(1'b0, 1'b0, BASE, "R4 cleared");
    bwrite(6'h04, 32'h0);

    // R6 async latency
    bwrite(6'h05, 32'h200);
    set_en(29'h200);
    irq_in[9] = 1'b1;
    cyc(3);
    pins(1'b0, 1'b0, BASE, "R6 before");
    cyc(1);
    pins(1'b0, 1'b1, BASE + 32'd36, "R6 after");
    irq_in[9] = 1'b0;
    set_en('0);
    cyc(4);

    // R7 masking
    irq_in[12] = 1'b1;
    cyc(3);
    pins(1'b0, 1'b0, BASE, "R7 disabled");
    bread(6'h00, 32'h1000, "R7 raw");
    bread(6'h01, 32'h0, "R7 masked off");
    set_en(29'h1000);
    bread(6'h01, 32'h1000, "R7 masked on");
    irq_in[12] = 1'b0;
    set_en('0);
    cyc(3);

    // R10 priority ordering
    irq_in[20] = 1'b1; irq_in[21] = 1'b1;
    set_en(29'h30_0000);
    cyc(3);
    pins(1'b0, 1'b1, BASE + 32'd80, "R10 tie lower index");
    bwrite(6'h35, 32'd1);
    bwrite(6'h34, 32'd2);
    cyc(1);
    pins(1'b0, 1'b1, BASE + 32'd84, "R10 lower value wins");
    bwrite(6'h35, 32'd2);
    cyc(1);
    pins(1'b0, 1'b1, BASE + 32'd80, "R10 tie again");
    bread(6'h35, 32'd2, "R10 prio readback");

    // R8 / R11 critical routing
    bwrite(6'h06, 32'h4000);
    irq_in[14] = 1'b1;
    set_en(29'h30_4000);
    cyc(3);
    pins(1'b1, 1'b1, BASE + 32'd80, "R11 crit excluded");
    irq_in[20] = 1'b0; irq_in[21] = 1'b0;
    cyc(3);
    pins(1'b1, 1'b0, BASE, "R8 crit only");
    bwrite(6'h06, 32'h0);
    cyc(1);
    pins(1'b0, 1'b1, BASE + 32'd56, "R8 rerouted normal");

    cyc(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule